// File: doc/BRIEF.md
# Serial Flash Slave Interface Front-End

This block is the pin-facing serial front-end of a small serial flash device. It runs on the device's internal clock and samples the chip-select, serial-clock, hold and data-in pins. Bits are taken on rising serial-clock edges and framed into bytes, most significant bit first. Each finished byte is handed to a command decoder over a simple byte port, and the first byte of every selection is flagged as the instruction. The address and data bytes follow it.

For reads, the decoder raises `readEn` and supplies bytes on `txByte`. The block shifts them out on falling serial-clock edges. A single-line read uses the data-out pin. A dual read also drives the data-in pin, so that two bits leave on each falling edge. The block owns output-enable control for both pins. It ignores the bus until chip select has fallen once after reset. It also implements a hold pause that freezes the transfer without ending the selection. Both clock idle levels (mode 0 and mode 3) are accepted.

Top module: `sfi_front`

## Requirements
- R1: While selected, each rising serial-clock edge shifts `diIn` into a byte MSB first; after 8 edges `rxValid` pulses for one clock with the byte on `rxByte`, and `rxFirst` is 1 only for the first byte since chip select fell.
- R2: With `readEn` high and `dualEn` low, each falling serial-clock edge puts the next bit of `txByte` on `doOut`, MSB first. The byte is taken at the first falling edge of every 8, and each take is followed by a one-clock `txReq` pulse that lets the decoder present the next byte.
- R3: While `csN` is high, `doOe` and `diOe` are 0.
- R4: After reset, no byte is reported and no output is enabled until `csN` has been seen going from high to low; a `csN` held low through reset does not count.
- R5: While a hold is in force, `doOe` and `diOe` are 0 and serial-clock edges are ignored. After release, the transfer resumes at the same bit position and the received and sent data are unchanged.
- R6: `holdN` is sampled only while the serial clock is low and the device is selected, so a hold pulse confined to a clock-high phase has no effect.
- R7: Mode 3 (clock idling high, so that the selection opens with a falling edge) captures and sends the same data as mode 0.
- R8: With `readEn` and `dualEn` high, each falling edge sends two bits: the higher bit on `doOut` and the lower bit on `diOut`. `diOe` is 1, and a byte takes 4 edges.
- R9: A rise of `csN` in the middle of a byte discards the partial byte. The next selection starts at bit 0, and its first byte is flagged by `rxFirst`.
- R10: `doOe` is 0 while `readEn` is low, and no `txReq` occurs without `readEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal device clock that samples the pins |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Chip select pin, active low |
| sclk | input | 1 | Serial clock pin |
| holdN | input | 1 | Hold pin, active low |
| diIn | input | 1 | Data-in pin, input path |
| diOut | output | 1 | Data-in pin, output value (dual read) |
| diOe | output | 1 | Data-in pin output enable |
| doOut | output | 1 | Data-out pin value |
| doOe | output | 1 | Data-out pin output enable |
| readEn | input | 1 | Decoder: output phase active |
| dualEn | input | 1 | Decoder: output on two lines |
| txByte | input | 8 | Decoder: byte to send |
| txReq | output | 1 | Pulse: txByte taken, present next |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | Pulse: rxByte is new |
| rxFirst | output | 1 | rxByte is the instruction byte |

## Verification
The assertions assume that the pins have already been synchronised to `clk` and that every serial-clock level lasts at least two clocks, so that two rising edges are never seen back to back. They also assume that hold is released only while the serial clock is low. The stimulus drives all pins on the falling edge of `clk` and holds each serial-clock phase for four clocks. It changes `diIn` only while the serial clock is low, and it releases hold only after the clock has returned low. The decoder side raises `readEn` only between bytes, while the serial clock is high.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  typedef struct packed {
    logic shiftIn;
    logic byteDone;
    logic firstByte;
    logic loadTx;
    logic shiftTx;
    logic dual;
    logic clear;
  } sfiStrobes_t;
endpackage

// File: rtl/sfi_ctrl.sv
module sfi_ctrl
  import sfi_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        holdN,
  input  logic        readEn,
  input  logic        dualEn,
  output sfiStrobes_t stb,
  output logic        armed,
  output logic        holdActive,
  output logic        sclkQ,
  output logic        csQ,
  output logic        doOe,
  output logic        diOe
);
  localparam int CntW = $clog2(ByteW) + 1;
  localparam logic [CntW-1:0] LastBit = CntW'(ByteW - 1);
  localparam logic [CntW-1:0] FullCnt = CntW'(ByteW);

  logic sclkPrev, csPrev, holdQ;
  logic sel, riseEv, fallEv, firstPend;
  logic [CntW-1:0] bitCnt, txCnt, stepN;

  // pin sampling; csQ/csPrev reset low so a select held through reset is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ      <= 1'b0;
      csPrev   <= 1'b0;
      sclkQ    <= 1'b0;
      sclkPrev <= 1'b0;
      holdQ    <= 1'b1;
    end else begin
      csQ      <= csN;
      csPrev   <= csQ;
      sclkQ    <= sclk;
      sclkPrev <= sclkQ;
      holdQ    <= holdN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (csPrev && !csQ) armed <= 1'b1;
  end

  assign sel = !csQ && armed;

  // hold only changes while the serial clock is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdActive <= 1'b0;
    else if (!sel) holdActive <= 1'b0;
    else if (!sclkQ) holdActive <= !holdQ;
  end

  assign riseEv = sel && !holdActive && sclkQ && !sclkPrev;
  assign fallEv = sel && !holdActive && !sclkQ && sclkPrev;
  assign stepN  = dualEn ? CntW'(2) : CntW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      firstPend <= 1'b1;
    end else if (!sel) begin
      bitCnt    <= '0;
      firstPend <= 1'b1;
    end else if (riseEv) begin
      bitCnt <= (bitCnt == LastBit) ? '0 : bitCnt + 1'b1;
      if (bitCnt == LastBit) firstPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txCnt <= '0;
    else if (!sel || !readEn) txCnt <= '0;
    else if (fallEv) txCnt <= (txCnt == '0) ? FullCnt - stepN : txCnt - stepN;
  end

  always_comb begin
    stb           = '0;
    stb.shiftIn   = riseEv;
    stb.byteDone  = riseEv && (bitCnt == LastBit);
    stb.firstByte = firstPend;
    stb.loadTx    = fallEv && readEn && (txCnt == '0);
    stb.shiftTx   = fallEv && readEn && (txCnt != '0);
    stb.dual      = dualEn;
    stb.clear     = !sel;
  end

  assign doOe = sel && readEn && !holdActive;
  assign diOe = doOe && dualEn;
endmodule

// File: rtl/sfi_datapath.sv
module sfi_datapath
  import sfi_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sfiStrobes_t      stb,
  input  logic             diIn,
  input  logic [ByteW-1:0] txByte,
  output logic [ByteW-1:0] rxByte,
  output logic             rxValid,
  output logic             rxFirst,
  output logic             txReq,
  output logic             doOut,
  output logic             diOut
);
  logic             diQ;
  logic [ByteW-1:0] rxShift, txShift, txSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) diQ <= 1'b0;
    else diQ <= diIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
      rxFirst <= 1'b0;
    end else begin
      rxValid <= stb.byteDone;
      if (stb.shiftIn) rxShift <= {rxShift[ByteW-2:0], diQ};
      if (stb.byteDone) begin
        rxByte  <= {rxShift[ByteW-2:0], diQ};
        rxFirst <= stb.firstByte;
      end
    end
  end

  assign txSrc = stb.loadTx ? txByte : txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      doOut   <= 1'b0;
      diOut   <= 1'b0;
      txReq   <= 1'b0;
    end else begin
      txReq <= stb.loadTx;
      if (stb.clear) begin
        txShift <= '0;
        doOut   <= 1'b0;
        diOut   <= 1'b0;
      end else if (stb.loadTx || stb.shiftTx) begin
        doOut   <= txSrc[ByteW-1];
        diOut   <= stb.dual ? txSrc[ByteW-2] : 1'b0;
        txShift <= stb.dual ? (txSrc << 2) : (txSrc << 1);
      end
    end
  end
endmodule

// File: rtl/sfi_front.sv
module sfi_front #(
  parameter int ByteW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             holdN,
  input  logic             diIn,
  output logic             diOut,
  output logic             diOe,
  output logic             doOut,
  output logic             doOe,
  input  logic             readEn,
  input  logic             dualEn,
  input  logic [ByteW-1:0] txByte,
  output logic             txReq,
  output logic [ByteW-1:0] rxByte,
  output logic             rxValid,
  output logic             rxFirst
);
  sfi_pkg::sfiStrobes_t stb;
  logic armed, holdActive, sclkQ, csQ;

  sfi_ctrl #(.ByteW(ByteW)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .holdN(holdN),
    .readEn(readEn), .dualEn(dualEn), .stb(stb), .armed(armed),
    .holdActive(holdActive), .sclkQ(sclkQ), .csQ(csQ),
    .doOe(doOe), .diOe(diOe)
  );

  sfi_datapath #(.ByteW(ByteW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .diIn(diIn), .txByte(txByte),
    .rxByte(rxByte), .rxValid(rxValid), .rxFirst(rxFirst), .txReq(txReq),
    .doOut(doOut), .diOut(diOut)
  );
endmodule

// File: rtl/sfi_front_chk.sv
module sfi_front_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic readEn,
  input logic doOe,
  input logic diOe,
  input logic txReq,
  input logic rxValid,
  input logic armed,
  input logic holdActive,
  input logic sclkQ,
  input logic csQ
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> (!doOe && !diOe)); // R3
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R1
  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!rxValid && !doOe && !txReq)); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> !rxValid); // R5
  AST_HOLD_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> ($past(!sclkQ) && $past(!csQ))); // R6
  AST_REQ_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> $past(readEn)); // R10
endmodule

bind sfi_front sfi_front_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .readEn(readEn), .doOe(doOe),
  .diOe(diOe), .txReq(txReq), .rxValid(rxValid), .armed(armed),
  .holdActive(holdActive), .sclkQ(sclkQ), .csQ(csQ)
);

// File: tb/sfi_front_bench.sv
module sfi_front_bench;
  localparam int H = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0, sclk = 1'b0, holdN = 1'b1, diIn = 1'b0;
  logic readEn = 1'b0, dualEn = 1'b0;
  logic [7:0] txByte;
  logic diOut, diOe, doOut, doOe, txReq, rxValid, rxFirst;
  logic [7:0] rxByte;

  int checks = 0, fails = 0;
  int reqCnt = 0, reqBase = 0, csHigh = 0;
  bit finished = 1'b0;
  logic [7:0] txMem [8] = '{8'hC5, 8'h3A, 8'h96, 8'h0F, 8'hE1, 8'h7B, 8'h48, 8'hD2};
  logic [7:0] rxQ [$];
  bit         rxF [$];

  always #5 clk = ~clk;

  sfi_front u_sfi_front (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .holdN(holdN),
    .diIn(diIn), .diOut(diOut), .diOe(diOe), .doOut(doOut), .doOe(doOe),
    .readEn(readEn), .dualEn(dualEn), .txByte(txByte), .txReq(txReq),
    .rxByte(rxByte), .rxValid(rxValid), .rxFirst(rxFirst)
  );

  assign txByte = txMem[(reqCnt - reqBase) % 8];

  // behavioural monitor of the decoder side
  always @(posedge clk) begin
    if (rxValid) begin
      rxQ.push_back(rxByte);
      rxF.push_back(rxFirst);
    end
    if (txReq) reqCnt <= reqCnt + 1;
    csHigh <= csN ? csHigh + 1 : 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-clock reference comparison of the output enables
  always @(negedge clk) begin
    if (rstN && csHigh >= 2) chk(!doOe && !diOe, "R3", {doOe, diOe}, 0);
    if (rstN && !readEn) chk(!doOe, "R10", doOe, 0);
    if (rstN && diOe) chk(dualEn && doOe, "R8", {dualEn, doOe}, 3);
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // holdKind 1: hold with clock low plus ignored clock toggles; 2: hold pulse in high phase
  task automatic bitXfer(input logic b, input int holdKind, output logic [1:0] s);
    sclk = 1'b0;
    diIn = b;
    waitClk(H);
    if (holdKind == 1) begin
      holdN = 1'b0;
      waitClk(3);
      chk(!doOe && !diOe, "R5 hold oe", {doOe, diOe}, 0);
      sclk = 1'b1; waitClk(3);
      sclk = 1'b0; waitClk(3);
      holdN = 1'b1; waitClk(3);
    end
    sclk = 1'b1;
    if (holdKind == 2) begin
      waitClk(1); holdN = 1'b0; waitClk(2); holdN = 1'b1; waitClk(H - 3);
    end else begin
      waitClk(H);
    end
    s = {doOut, diOut};
  endtask

  task automatic byteXfer(input logic [7:0] v, input int holdBit, input int kind,
                          output logic [7:0] got);
    logic [1:0] s;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(v[i], (i == holdBit) ? kind : 0, s);
      got[i] = s[1];
    end
  endtask

  task automatic dualByte(output logic [7:0] got);
    logic [1:0] s;
    for (int k = 3; k >= 0; k--) begin
      bitXfer(1'b0, 0, s);
      got[2*k+1] = s[1];
      got[2*k]   = s[0];
      chk(diOe, "R8 diOe", diOe, 1);
    end
  endtask

  task automatic selectOn(input bit mode3);
    sclk = mode3;
    waitClk(2);
    csN = 1'b0;
    waitClk(H);
  endtask

  task automatic selectOff(input bit mode3);
    if (!mode3) begin
      sclk = 1'b0;
      waitClk(H);
    end
    csN = 1'b1;
    waitClk(H);
  endtask

  task automatic sendHdr(input logic [7:0] ins);
    logic [7:0] g;
    byteXfer(ins, -1, 0, g);
    byteXfer(8'h12, -1, 0, g);
    byteXfer(8'h34, -1, 0, g);
    byteXfer(8'h56, -1, 0, g);
  endtask

  task automatic startRead(input bit dual);
    waitClk(2);
    chk(!doOe, "R10 before read", doOe, 0);
    reqBase = reqCnt;
    dualEn = dual;
    readEn = 1'b1;
  endtask

  task automatic stopRead();
    readEn = 1'b0;
    dualEn = 1'b0;
  endtask

  task automatic clearQ();
    rxQ.delete();
    rxF.delete();
  endtask

  initial begin
    logic [7:0] g;
    // csN held low through reset
    waitClk(3);
    chk(!doOe && !diOe && !rxValid, "R4 reset", {doOe, diOe, rxValid}, 0);
    rstN = 1'b1;
    waitClk(3);
    chk(!doOe && !rxValid, "R3 reset state", {doOe, rxValid}, 0);
    byteXfer(8'hFF, -1, 0, g);
    byteXfer(8'h03, -1, 0, g);
    waitClk(3);
    chk(rxQ.size() == 0, "R4 no edge no capture", rxQ.size(), 0);
    selectOff(1'b0);
    clearQ();

    // R1: mode 0 write-style frame
    selectOn(1'b0);
    sendHdr(8'h02);
    byteXfer(8'hC3, -1, 0, g);
    selectOff(1'b0);
    chk(rxQ.size() == 5, "R1 count", rxQ.size(), 5);
    if (rxQ.size() == 5) begin
      chk(rxQ[0] == 8'h02 && rxF[0], "R1 instruction", {rxF[0], rxQ[0]}, 9'h102);
      chk(rxQ[1] == 8'h12 && rxQ[2] == 8'h34 && rxQ[3] == 8'h56, "R1 address",
          {rxQ[1], rxQ[2], rxQ[3]}, 24'h123456);
      chk(rxQ[4] == 8'hC3 && !rxF[4] && !rxF[1], "R1 data", {rxF[4], rxQ[4]}, 9'h0C3);
    end
    clearQ();

    // R9: abort mid-byte
    selectOn(1'b0);
    begin
      logic [1:0] s;
      for (int i = 0; i < 5; i++) bitXfer(1'b1, 0, s);
    end
    selectOff(1'b0);
    selectOn(1'b0);
    byteXfer(8'hA5, -1, 0, g);
    selectOff(1'b0);
    chk(rxQ.size() == 1, "R9 count", rxQ.size(), 1);
    if (rxQ.size() == 1)
      chk(rxQ[0] == 8'hA5 && rxF[0], "R9 fresh byte", {rxF[0], rxQ[0]}, 9'h1A5);
    clearQ();

    // R2: single-line read, mode 0
    selectOn(1'b0);
    sendHdr(8'h03);
    startRead(1'b0);
    byteXfer(8'h00, -1, 0, g);
    chk(g == txMem[0], "R2 byte0", g, txMem[0]);
    byteXfer(8'h00, -1, 0, g);
    chk(g == txMem[1], "R2 byte1", g, txMem[1]);
    chk(reqCnt - reqBase == 2, "R2 txReq", reqCnt - reqBase, 2);
    stopRead();
    selectOff(1'b0);
    clearQ();

    // R7: mode 3 read
    selectOn(1'b1);
    sendHdr(8'h0B);
    chk(rxQ.size() == 4 && rxQ[0] == 8'h0B && rxQ[3] == 8'h56, "R7 capture",
        rxQ.size() > 0 ? rxQ[0] : 0, 8'h0B);
    startRead(1'b0);
    byteXfer(8'h00, -1, 0, g);
    chk(g == txMem[0], "R7 byte0", g, txMem[0]);
    byteXfer(8'h00, -1, 0, g);
    chk(g == txMem[1], "R7 byte1", g, txMem[1]);
    stopRead();
    selectOff(1'b1);
    clearQ();

    // R8: dual read
    selectOn(1'b0);
    sendHdr(8'h3B);
    startRead(1'b1);
    dualByte(g);
    chk(g == txMem[0], "R8 byte0", g, txMem[0]);
    dualByte(g);
    chk(g == txMem[1], "R8 byte1", g, txMem[1]);
    stopRead();
    selectOff(1'b0);
    clearQ();

    // R5: hold while receiving and while sending
    selectOn(1'b0);
    byteXfer(8'h5A, 3, 1, g);
    waitClk(2);
    chk(rxQ.size() == 1 && rxQ[0] == 8'h5A, "R5 rx after hold",
        rxQ.size() > 0 ? rxQ[0] : 0, 8'h5A);
    byteXfer(8'h00, -1, 0, g);
    byteXfer(8'h00, -1, 0, g);
    byteXfer(8'h00, -1, 0, g);
    startRead(1'b0);
    byteXfer(8'h00, 2, 1, g);
    chk(g == txMem[0], "R5 tx after hold", g, txMem[0]);
    stopRead();
    selectOff(1'b0);
    clearQ();

    // R6: hold pulse only in clock-high phase is ignored
    selectOn(1'b0);
    byteXfer(8'h69, 4, 2, g);
    selectOff(1'b0);
    chk(rxQ.size() == 1 && rxQ[0] == 8'h69, "R6 high-phase hold",
        rxQ.size() > 0 ? rxQ[0] : 0, 8'h69);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule